// File: doc/BRIEF.md
# Flash Operation Status Poller

This block sits on the host side of a parallel NOR-style flash bus. Once software has started a program or erase operation on the flash, it pulses `start` and the poller works out, only from the status byte the flash returns on reads, whether the operation has finished, failed, or is still running. The status byte has three flags that matter here. The toggle flag changes on every read while the internal operation is running. The limit flag reports that the internal time limit was exceeded. The window flag reports whether the sector-erase queueing window has closed.

In completion mode the poller reads the status in pairs and compares the toggle flag within each pair. If the limit flag is set, it runs one more confirming pair before it declares a failure. On a confirmed failure it writes the recovery command to the flash and then reports. In queue mode it adds one more sector to a pending erase. It checks the window flag, writes the caller's command byte, and checks the window flag again to decide whether the command was taken. Every strobe obeys a minimum low and high width counted in clock cycles. A watchdog limits the length of any operation.

Top module: `flash_status_poller`

## Requirements
- R1: While and directly after reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are 1 and `res_valid` is 0.
- R2: Each bus access holds `bus_ce_n` low together with exactly one of `bus_oe_n`/`bus_we_n` for exactly LOW_W cycles. Chip enable stays high for at least HIGH_W cycles between accesses. Read enable and write enable are never low together.
- R3: In completion mode (`mode`=0) the poller reads the status in pairs. If bit 6 (toggle flag) is equal in both reads of a pair, it reports code 01 (done).
- R4: If bit 6 differs within a pair and bit 5 (limit flag) of the second read is 0, it starts a new pair and does not report.
- R5: If bit 6 differs and bit 5 of the second read is 1, one confirming pair follows. If bit 6 is equal in that pair, the code is 01.
- R6: If bit 6 still differs in the confirming pair, the poller makes one write of RESET_CMD to the latched address and then reports code 10 (fail).
- R7: In queue mode (`mode`=1) the first read checks bit 3 (window flag). If it is 1, the code is 11 (rejected) and no write takes place.
- R8: Otherwise the poller writes `cmd_data` to `cmd_addr` and reads again. If bit 3 is now 1 the code is 11, else 01.
- R9: If no result arrives within WDOG_CYC cycles of `start`, the code is 00 (still busy). All strobes are high in the cycle `res_valid` rises.
- R10: Each accepted `start` gives exactly one `res_valid` pulse, one cycle long.
- R11: A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 1 | 0 = poll for completion, 1 = queue a sector-erase command |
| cmd_addr | input | AW | Address used for status reads and writes |
| cmd_data | input | DW | Command byte written in queue mode |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 00 busy/timeout, 01 done, 10 fail, 11 rejected |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_rdata | input | DW | Flash read data (status byte) |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read enable, active low |
| bus_we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is the confirmed failure. The toggle flag must keep changing through the pair that raises the limit flag and also through the confirming pair after it, and the late-completion case needs the toggling to stop exactly between those two pairs. The bench's flash model computes each status byte from a read counter. Settings for how many reads toggle and from which read the limit flag is set place the stop before, inside, or never relative to the confirming pair. The window flag changes value once the model sees a write, which is how both rejection paths of queue mode are reached.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    RES_BUSY   = 2'b00,
    RES_DONE   = 2'b01,
    RES_FAIL   = 2'b10,
    RES_REJECT = 2'b11
  } res_code_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_RST_WR,
    S_Q_PRE,
    S_Q_WR,
    S_Q_POST
  } seq_state_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_LOW,
    P_HIGH
  } strobe_phase_t;
endpackage

// File: rtl/fsp_strobe.sv
module fsp_strobe #(
  parameter int DW     = 8,
  parameter int LOW_W  = 3,
  parameter int HIGH_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kill,
  input  logic          go,
  input  logic          is_wr,
  input  logic [DW-1:0] rdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] rd_q,
  output logic          done
);
  import fsp_pkg::*;

  localparam int MAXW = (LOW_W > HIGH_W) ? LOW_W : HIGH_W;
  localparam int CW   = $clog2(MAXW + 1);

  strobe_phase_t phase;
  logic [CW-1:0] cnt;
  logic          wr_mode;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      phase   <= P_IDLE;
      cnt     <= '0;
      wr_mode <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      done    <= 1'b0;
      if (rst) rd_q <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        P_IDLE: if (go) begin
          phase   <= P_LOW;
          cnt     <= CW'(LOW_W - 1);
          wr_mode <= is_wr;
          ce_n    <= 1'b0;
          oe_n    <= is_wr;
          we_n    <= !is_wr;
        end
        P_LOW: if (cnt == '0) begin
          ce_n  <= 1'b1;
          oe_n  <= 1'b1;
          we_n  <= 1'b1;
          if (!wr_mode) rd_q <= rdata;
          cnt   <= CW'(HIGH_W - 1);
          phase <= P_HIGH;
        end else begin
          cnt <= cnt - 1'b1;
        end
        P_HIGH: if (cnt == '0) begin
          done  <= 1'b1;
          phase <= P_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: phase <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsp_wdog.sv
module fsp_wdog #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (run) begin
        if (cnt == CW'(LIMIT - 1)) begin
          cnt     <= '0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int          AW        = 19,
  parameter int          DW        = 8,
  parameter int          TOG_BIT   = 6,
  parameter int          LIM_BIT   = 5,
  parameter int          WIN_BIT   = 3,
  parameter int          LOW_W     = 3,
  parameter int          HIGH_W    = 2,
  parameter int          WDOG_CYC  = 100000,
  parameter logic [DW-1:0] RESET_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          res_valid,
  output logic [1:0]    res_code,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_ce_n,
  output logic          bus_oe_n,
  output logic          bus_we_n
);
  import fsp_pkg::*;

  seq_state_t    state;
  logic          go;
  logic          go_wr;
  logic          recheck;
  logic          tog_a;
  logic          st_done;
  logic [DW-1:0] st_rd;
  logic          wd_exp;
  logic          abort;
  logic          accept;

  assign accept = (state == S_IDLE) && start;
  assign abort  = wd_exp && (state != S_IDLE);

  fsp_strobe #(.DW(DW), .LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_strobe (
    .clk   (clk),
    .rst   (rst),
    .kill  (abort),
    .go    (go),
    .is_wr (go_wr),
    .rdata (bus_rdata),
    .ce_n  (bus_ce_n),
    .oe_n  (bus_oe_n),
    .we_n  (bus_we_n),
    .rd_q  (st_rd),
    .done  (st_done)
  );

  fsp_wdog #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .run     (state != S_IDLE),
    .expired (wd_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      go        <= 1'b0;
      go_wr     <= 1'b0;
      recheck   <= 1'b0;
      tog_a     <= 1'b0;
      res_valid <= 1'b0;
      res_code  <= RES_BUSY;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      go        <= 1'b0;
      res_valid <= 1'b0;
      if (abort) begin
        state     <= S_IDLE;
        res_valid <= 1'b1;
        res_code  <= RES_BUSY;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            bus_addr  <= cmd_addr;
            bus_wdata <= cmd_data;
            recheck   <= 1'b0;
            go        <= 1'b1;
            go_wr     <= 1'b0;
            state     <= mode ? S_Q_PRE : S_RD_A;
          end
          S_RD_A: if (st_done) begin
            tog_a <= st_rd[TOG_BIT];
            go    <= 1'b1;
            go_wr <= 1'b0;
            state <= S_RD_B;
          end
          S_RD_B: if (st_done) begin
            if (tog_a == st_rd[TOG_BIT]) begin
              state     <= S_IDLE;
              res_valid <= 1'b1;
              res_code  <= RES_DONE;
            end else if (recheck) begin
              bus_wdata <= RESET_CMD;
              go        <= 1'b1;
              go_wr     <= 1'b1;
              state     <= S_RST_WR;
            end else begin
              recheck <= st_rd[LIM_BIT];
              go      <= 1'b1;
              go_wr   <= 1'b0;
              state   <= S_RD_A;
            end
          end
          S_RST_WR: if (st_done) begin
            state     <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= RES_FAIL;
          end
          S_Q_PRE: if (st_done) begin
            if (st_rd[WIN_BIT]) begin
              state     <= S_IDLE;
              res_valid <= 1'b1;
              res_code  <= RES_REJECT;
            end else begin
              go    <= 1'b1;
              go_wr <= 1'b1;
              state <= S_Q_WR;
            end
          end
          S_Q_WR: if (st_done) begin
            go    <= 1'b1;
            go_wr <= 1'b0;
            state <= S_Q_POST;
          end
          S_Q_POST: if (st_done) begin
            state     <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= st_rd[WIN_BIT] ? RES_REJECT : RES_DONE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int LOW_W = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_ce_n,
  input logic       bus_oe_n,
  input logic       bus_we_n,
  input logic       res_valid,
  input logic [1:0] res_code
);
  logic [15:0] oe_lo;
  logic [15:0] we_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_lo <= '0;
      we_lo <= '0;
    end else begin
      oe_lo <= bus_oe_n ? 16'd0 : oe_lo + 16'd1;
      we_lo <= bus_we_n ? 16'd0 : we_lo + 16'd1;
    end
  end

  // R2
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));

  // R2
  ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ce_n |-> (bus_oe_n && bus_we_n));

  // R2
  oe_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_oe_n) && !res_valid) |-> (oe_lo == 16'(LOW_W)));

  // R2
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_we_n) && !res_valid) |-> (we_lo == 16'(LOW_W)));

  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == 2'b00) |-> (bus_ce_n && bus_oe_n && bus_we_n));
endmodule

bind flash_status_poller fsp_chk #(.LOW_W(LOW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_ce_n  (bus_ce_n),
  .bus_oe_n  (bus_oe_n),
  .bus_we_n  (bus_we_n),
  .res_valid (res_valid),
  .res_code  (res_code)
);

// File: tb/flash_status_poller_tb.sv
module flash_status_poller_tb;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int LOW_W = 3;
  localparam int HIGH_W = 2;
  localparam int WDOG = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic res_valid;
  logic [1:0] res_code;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_ce_n, bus_oe_n, bus_we_n;

  int n_pass = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  flash_status_poller #(.AW(AW), .DW(DW), .LOW_W(LOW_W), .HIGH_W(HIGH_W),
                        .WDOG_CYC(WDOG)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .res_valid(res_valid), .res_code(res_code),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n));

  // flash status model
  int rd_idx = 0, rd_base = 0, wr_cnt = 0, wr_base = 0;
  int n_tog = 0, tl_from = 1000000;
  logic stick = 1'b0, win_pre = 1'b0, win_post = 1'b0;
  logic [DW-1:0] last_wd = '0;
  logic [AW-1:0] last_wa = '0;

  function automatic logic [DW-1:0] status(int i);
    logic [DW-1:0] s = '0;
    s[6] = stick ? i[0] : ((i < n_tog) ? i[0] : 1'b0);
    s[5] = (i >= tl_from);
    s[3] = (wr_cnt == wr_base) ? win_pre : win_post;
    return s;
  endfunction

  always @(negedge bus_oe_n) begin
    bus_rdata <= status(rd_idx - rd_base);
    rd_idx <= rd_idx + 1;
  end

  always @(negedge bus_we_n) begin
    last_wd <= bus_wdata;
    last_wa <= bus_addr;
    wr_cnt <= wr_cnt + 1;
  end

  // strobe width monitor
  int lo_run = 0, hi_run = 0, lo_bad = 0, hi_min = 1000000;
  logic seen_lo = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_ce_n) begin
        if (hi_run > 0 && seen_lo && hi_run < hi_min) hi_min = hi_run;
        hi_run = 0;
        lo_run++;
        seen_lo = 1'b1;
      end else begin
        if (lo_run > 0 && lo_run != LOW_W) lo_bad++;
        lo_run = 0;
        hi_run++;
      end
    end
  end

  task automatic chk(int act, int exp, string tag);
    if (act == exp) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm(int tog, logic stk, int tl, logic wp, logic wq);
    n_tog = tog; stick = stk; tl_from = tl; win_pre = wp; win_post = wq;
    rd_base = rd_idx; wr_base = wr_cnt;
  endtask

  task automatic launch(logic m, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    mode = m; cmd_addr = a; cmd_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_res(output int code, output int pulses);
    code = -1; pulses = 0;
    for (int i = 0; i < 3000 && pulses == 0; i++) begin
      @(negedge clk);
      if (res_valid) begin
        code = res_code; pulses = 1;
        @(negedge clk);
        if (res_valid) pulses = 2;
      end
    end
    repeat (5) begin
      @(negedge clk);
      if (res_valid) pulses++;
    end
  endtask

  task automatic t_reset();
    chk(res_valid, 0, "R1 res_valid");
    chk({bus_ce_n, bus_oe_n, bus_we_n}, 7, "R1 strobes idle");
  endtask

  task automatic t_poll_slow();
    int c, p;
    arm(5, 0, 1000000, 0, 0);
    launch(0, 19'h1234, 8'h00);
    wait_res(c, p);
    chk(c, 1, "R3/R4 done after toggling stops");
    chk(rd_idx - rd_base, 6, "R4 reads in pairs until equal");
    chk(p, 1, "R10 single pulse");
  endtask

  task automatic t_poll_quick();
    int c, p;
    arm(0, 0, 1000000, 0, 0);
    launch(0, 19'h0042, 8'h00);
    wait_res(c, p);
    chk(c, 1, "R3 immediate done");
    chk(rd_idx - rd_base, 2, "R3 one pair");
  endtask

  task automatic t_late_done();
    int c, p;
    arm(6, 0, 4, 0, 0);
    launch(0, 19'h0100, 8'h00);
    wait_res(c, p);
    chk(c, 1, "R5 late completion is done");
    chk(rd_idx - rd_base, 8, "R5 confirming pair read");
    chk(wr_cnt - wr_base, 0, "R5 no recovery write");
  endtask

  task automatic t_fail();
    int c, p;
    arm(0, 1, 2, 0, 0);
    launch(0, 19'h2AAAA, 8'h00);
    wait_res(c, p);
    chk(c, 2, "R6 fail code");
    chk(rd_idx - rd_base, 6, "R6 reads before failure");
    chk(wr_cnt - wr_base, 1, "R6 one recovery write");
    chk(last_wd, 8'hF0, "R6 recovery data");
    chk(last_wa, 19'h2AAAA, "R6 recovery address");
  endtask

  task automatic t_queue_ok();
    int c, p;
    arm(0, 0, 1000000, 0, 0);
    launch(1, 19'h30000, 8'h30);
    wait_res(c, p);
    chk(c, 1, "R8 accepted");
    chk(wr_cnt - wr_base, 1, "R8 one write");
    chk(last_wd, 8'h30, "R8 write data");
    chk(last_wa, 19'h30000, "R8 write address");
    chk(rd_idx - rd_base, 2, "R8 pre and post read");
  endtask

  task automatic t_queue_post_rej();
    int c, p;
    arm(0, 0, 1000000, 0, 1);
    launch(1, 19'h40000, 8'h30);
    wait_res(c, p);
    chk(c, 3, "R8 rejected on post check");
    chk(wr_cnt - wr_base, 1, "R8 write issued");
  endtask

  task automatic t_queue_pre_rej();
    int c, p;
    arm(0, 0, 1000000, 1, 1);
    launch(1, 19'h50000, 8'h30);
    wait_res(c, p);
    chk(c, 3, "R7 rejected on pre check");
    chk(wr_cnt - wr_base, 0, "R7 no write");
    chk(rd_idx - rd_base, 1, "R7 single read");
  endtask

  task automatic t_busy_start();
    int c, p;
    arm(5, 0, 1000000, 0, 0);
    launch(0, 19'h00010, 8'h00);
    repeat (8) @(negedge clk);
    launch(1, 19'h7FFFF, 8'h55);
    wait_res(c, p);
    chk(c, 1, "R11 first operation result");
    chk(p, 1, "R11 one result only");
    chk(wr_cnt - wr_base, 0, "R11 second start wrote nothing");
    chk(rd_idx - rd_base, 6, "R11 read count unchanged");
  endtask

  task automatic t_timeout();
    int c, p;
    arm(0, 1, 1000000, 0, 0);
    launch(0, 19'h00020, 8'h00);
    wait_res(c, p);
    chk(c, 0, "R9 timeout code");
    chk(p, 1, "R10 timeout single pulse");
    chk({bus_ce_n, bus_oe_n, bus_we_n}, 7, "R9 strobes released");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_poll_slow();
    t_poll_quick();
    t_late_done();
    t_fail();
    t_queue_ok();
    t_queue_post_rej();
    t_queue_pre_rej();
    t_busy_start();
    chk(lo_bad, 0, "R2 strobe low width");
    chk(hi_min >= HIGH_W, 1, "R2 strobe high gap");
    t_timeout();
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule